// File: doc/BRIEF.md
# Fuse Array Read Controller

This block is a register-mapped controller that reads 16-bit words out of a one-time-programmable fuse array. The array holds 32 blocks. Software uses a small register bus: it selects a block, issues a read command and polls a status word until the result is ready. It then fetches the block from a data register and acknowledges completion with an explicit clear command. An external module-enable input must be high for the controller to accept work. Software raises it before an access and drops it afterwards.

Each read holds a select strobe and a block address towards a synchronous fuse array for a programmable number of clock cycles. The array answers one clock after it is addressed. The controller captures the answer in the last cycle of the window. A sticky completion flag and a standby flag tell software when data is valid and when a new read may be issued.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After synchronous reset the busy and done flags are clear, the block index reads 0, the data register reads 0 and the timing register reads 8.
- R2: The registers sit at these byte offsets: data at 0x04 (read-only), block index at 0x0C, command at 0x10, status at 0x14 and read timing at 0x24. The data register returns the captured 16-bit block in bits 15:0, with bits 31:16 zero.
- R3: The block index register keeps only write-data bits 4:0 and reads back those bits, with the upper bits zero. The stored index picks the block that the next read fetches.
- R4: Writing the command register with bit 1 set while standby is high starts a read. From the next cycle, status bit 1 (busy) is high, status bit 2 (standby) is low, `fa_sel` is high and `fa_addr` equals the block index.
- R5: A read stays busy for exactly N cycles, where N is the timing register value, with values below 2 treated as 2. At the end, busy falls, status bit 4 (done) rises, and the data register takes the block the array returned for `fa_addr`.
- R6: The done flag stays set until the command register is written with bit 2 set. Writing 0 to the command register changes nothing, and the command register always reads 0.
- R7: A read command is ignored while a read is in progress or while `mod_en` is low. No new read window starts, and the ongoing read is neither lengthened nor restarted.
- R8: Status bit 2 (standby) equals `mod_en` AND NOT busy. Status bit 0 (program busy) and bit 3 (protection) always read 0. A command with bit 0 (program start) set changes no status bit.
- R9: A write to the block index during a read leaves `fa_addr` and the captured result of that read unchanged. The new index applies to the next read.
- R10: The timing register stores write-data bits 7:0 and reads them back, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Module enable; the controller accepts reads only while high |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| fa_sel | output | 1 | Fuse array select, high for the whole read window |
| fa_addr | output | 5 | Fuse array block address, held during the window |
| fa_rdata | input | 16 | Fuse array data, valid one cycle after it is addressed |

## Verification
The assertions assume two things about the inputs. Bus writes are single-cycle strobes to the listed offsets. The fuse array presents the addressed block's data one clock after `fa_sel` rises and holds it for the rest of the window. The bench array model registers its data from `fa_addr` on every selected clock, and every tested window is at least two cycles long. The bench changes `mod_en` only while the controller is idle, so the assertions never see a read window with the enable low.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int BLK_W   = 16;
    localparam int BLK_CNT = 32;
    localparam int IDX_W   = $clog2(BLK_CNT);
    localparam int TIM_W   = 8;

    localparam logic [TIM_W-1:0] TIM_DEFAULT = TIM_W'(8);
    localparam logic [TIM_W-1:0] TIM_MIN     = TIM_W'(2);

    // register byte offsets
    localparam logic [ADDR_W-1:0] OFS_DATA  = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] OFS_INDEX = ADDR_W'(8'h0C);
    localparam logic [ADDR_W-1:0] OFS_CMD   = ADDR_W'(8'h10);
    localparam logic [ADDR_W-1:0] OFS_STAT  = ADDR_W'(8'h14);
    localparam logic [ADDR_W-1:0] OFS_TIM   = ADDR_W'(8'h24);

    // command bit positions
    localparam int CMD_PGM = 0;
    localparam int CMD_RD  = 1;
    localparam int CMD_CLR = 2;

    localparam int STAT_W = 5;

    // status word, MSB first: done, prot, standby, busy, program busy
    typedef struct packed {
        logic rd_done;
        logic glb_prot;
        logic standby;
        logic rd_busy;
        logic pgm_busy;
    } fuse_stat_t;

    typedef struct packed {
        logic pgm_go;
        logic rd_go;
        logic clr_done;
    } fuse_cmd_t;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_READ
    } seq_state_t;

    function automatic logic [TIM_W-1:0] eff_timing(input logic [TIM_W-1:0] v);
        return (v < TIM_MIN) ? TIM_MIN : v;
    endfunction

    function automatic logic [DATA_W-1:0] zext_blk(input logic [BLK_W-1:0] d);
        return {{(DATA_W-BLK_W){1'b0}}, d};
    endfunction

endpackage

// File: rtl/fuse_rd_regs.sv
module fuse_rd_regs
    import fuse_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  fuse_stat_t        stat,
    input  logic [DATA_W-1:0] rd_word,
    output logic [IDX_W-1:0]  blk_idx,
    output logic [TIM_W-1:0]  rd_cycles,
    output fuse_cmd_t         cmd,
    output logic [DATA_W-1:0] bus_rdata
);

    logic [TIM_W-1:0] tim_q;
    logic             wr_index;
    logic             wr_tim;
    logic             wr_cmd;
    logic             unused_wbits;

    assign wr_index = bus_we && (bus_addr == OFS_INDEX);
    assign wr_tim   = bus_we && (bus_addr == OFS_TIM);
    assign wr_cmd   = bus_we && (bus_addr == OFS_CMD);

    assign unused_wbits = ^bus_wdata[DATA_W-1:TIM_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_idx <= '0;
            tim_q   <= TIM_DEFAULT;
        end else begin
            if (wr_index) blk_idx <= bus_wdata[IDX_W-1:0];
            if (wr_tim)   tim_q   <= bus_wdata[TIM_W-1:0];
        end
    end

    assign rd_cycles = eff_timing(tim_q);

    // one-cycle command pulses; zeros do nothing
    always_comb begin
        cmd.pgm_go   = wr_cmd && bus_wdata[CMD_PGM];
        cmd.rd_go    = wr_cmd && bus_wdata[CMD_RD];
        cmd.clr_done = wr_cmd && bus_wdata[CMD_CLR];
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_DATA:  bus_rdata = rd_word;
            OFS_INDEX: bus_rdata = {{(DATA_W-IDX_W){1'b0}}, blk_idx};
            OFS_STAT:  bus_rdata = {{(DATA_W-STAT_W){1'b0}}, stat};
            OFS_TIM:   bus_rdata = {{(DATA_W-TIM_W){1'b0}}, tim_q};
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
    import fuse_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mod_en,
    input  fuse_cmd_t         cmd,
    input  logic [IDX_W-1:0]  blk_idx,
    input  logic [TIM_W-1:0]  rd_cycles,
    input  logic [BLK_W-1:0]  fa_rdata,
    output fuse_stat_t        stat,
    output logic [DATA_W-1:0] rd_word,
    output logic              fa_sel,
    output logic [IDX_W-1:0]  fa_addr
);

    seq_state_t       state;
    logic [TIM_W-1:0] cnt;
    logic [IDX_W-1:0] lat_idx;
    logic             done_q;
    logic             standby;
    logic             last_cyc;
    logic             unused_pgm;

    assign standby    = mod_en && (state == SEQ_IDLE);
    assign last_cyc   = (state == SEQ_READ) && (cnt == '0);
    // programming is not supported here; its command is accepted and dropped
    assign unused_pgm = cmd.pgm_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            cnt     <= '0;
            lat_idx <= '0;
            rd_word <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (cmd.rd_go && standby) begin
                        state   <= SEQ_READ;
                        cnt     <= rd_cycles - 1'b1;
                        lat_idx <= blk_idx;
                    end
                end
                SEQ_READ: begin
                    if (last_cyc) begin
                        state   <= SEQ_IDLE;
                        rd_word <= zext_blk(fa_rdata);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // completion takes priority over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)               done_q <= 1'b0;
        else if (last_cyc)     done_q <= 1'b1;
        else if (cmd.clr_done) done_q <= 1'b0;
    end

    assign fa_sel  = (state == SEQ_READ);
    assign fa_addr = lat_idx;

    always_comb begin
        stat.rd_done  = done_q;
        stat.glb_prot = 1'b0;
        stat.standby  = standby;
        stat.rd_busy  = (state == SEQ_READ);
        stat.pgm_busy = 1'b0;
    end

endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
    import fuse_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mod_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              fa_sel,
    output logic [IDX_W-1:0]  fa_addr,
    input  logic [BLK_W-1:0]  fa_rdata
);

    fuse_stat_t        stat_w;
    fuse_cmd_t         cmd_w;
    logic [IDX_W-1:0]  blk_idx_w;
    logic [TIM_W-1:0]  rd_cycles_w;
    logic [DATA_W-1:0] rd_word_w;

    fuse_rd_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .stat      (stat_w),
        .rd_word   (rd_word_w),
        .blk_idx   (blk_idx_w),
        .rd_cycles (rd_cycles_w),
        .cmd       (cmd_w),
        .bus_rdata (bus_rdata)
    );

    fuse_rd_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .mod_en    (mod_en),
        .cmd       (cmd_w),
        .blk_idx   (blk_idx_w),
        .rd_cycles (rd_cycles_w),
        .fa_rdata  (fa_rdata),
        .stat      (stat_w),
        .rd_word   (rd_word_w),
        .fa_sel    (fa_sel),
        .fa_addr   (fa_addr)
    );

endmodule

// File: rtl/fuse_rd_chk.sv
module fuse_rd_chk
    import fuse_rd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             mod_en,
    input fuse_stat_t       stat,
    input fuse_cmd_t        cmd,
    input logic             fa_sel,
    input logic [IDX_W-1:0] fa_addr
);

    // R8
    busy_standby_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(stat.rd_busy && stat.standby));

    // R8
    standby_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        stat.standby |-> mod_en);

    // R4
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.rd_go && stat.standby) |=> (stat.rd_busy && fa_sel));

    // R7
    start_disabled_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.rd_go && !mod_en && !stat.rd_busy) |=> !stat.rd_busy);

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fa_sel && $past(fa_sel)) |-> $stable(fa_addr));

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (stat.rd_done && !cmd.clr_done) |=> stat.rd_done);

    // R5
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.rd_done) |-> $past(stat.rd_busy));

endmodule

bind fuse_rd_ctrl fuse_rd_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .mod_en  (mod_en),
    .stat    (stat_w),
    .cmd     (cmd_w),
    .fa_sel  (fa_sel),
    .fa_addr (fa_addr)
);

// File: tb/test_fuse_rd_ctrl.sv
`timescale 1ns/1ps
module test_fuse_rd_ctrl;

    localparam logic [7:0] A_DATA  = 8'h04;
    localparam logic [7:0] A_INDEX = 8'h0C;
    localparam logic [7:0] A_CMD   = 8'h10;
    localparam logic [7:0] A_STAT  = 8'h14;
    localparam logic [7:0] A_TIM   = 8'h24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mod_en = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        fa_sel;
    logic [4:0]  fa_addr;
    logic [15:0] fa_rdata = 16'h0;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    fuse_rd_ctrl i_fuse_rd_ctrl (
        .clk(clk), .rst(rst), .mod_en(mod_en),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .fa_sel(fa_sel), .fa_addr(fa_addr),
        .fa_rdata(fa_rdata)
    );

    function automatic logic [15:0] pat(input logic [4:0] a);
        return {3'b101, a, 3'b010, a ^ 5'h1F};
    endfunction

    // synchronous fuse array model: data one clock after addressing
    always_ff @(posedge clk) begin
        if (fa_sel) fa_rdata <= pat(fa_addr);
    end

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_done(output int cnt);
        logic [31:0] s;
        cnt = 0;
        rd(A_STAT, s);
        while (s[1] && cnt < 1000) begin
            cnt++;
            @(negedge clk);
            rd(A_STAT, s);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_STAT, v);  check_eq("R1 status after reset", v, 32'h0);
        rd(A_DATA, v);  check_eq("R1 data after reset", v, 32'h0);
        rd(A_INDEX, v); check_eq("R1 index after reset", v, 32'h0);
        rd(A_TIM, v);   check_eq("R1 R10 timing default", v, 32'h8);
        rd(A_CMD, v);   check_eq("R6 command reads zero", v, 32'h0);
        check_eq("R1 fa_sel idle", {31'h0, fa_sel}, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        @(negedge clk); mod_en = 1'b1;
        #1; rd(A_STAT, v);
        check_eq("R8 standby follows enable", v, 32'h04);
    endtask

    task automatic t_basic_read();
        logic [31:0] v;
        int c;
        wr(A_INDEX, 32'h5);
        wr(A_CMD, 32'h2);
        check_eq("R4 fa_sel high", {31'h0, fa_sel}, 32'h1);
        check_eq("R4 fa_addr is index", {27'h0, fa_addr}, 32'h5);
        rd(A_STAT, v); check_eq("R4 busy not standby", v, 32'h02);
        wait_done(c);
        check_eq("R5 busy cycles default", c, 32'd8);
        rd(A_STAT, v); check_eq("R5 done and standby", v, 32'h14);
        rd(A_DATA, v); check_eq("R2 R5 data block 5", v, {16'h0, pat(5'd5)});
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        idle(10);
        rd(A_STAT, v); check_eq("R6 done stays set", v, 32'h14);
        wr(A_CMD, 32'h0);
        rd(A_STAT, v); check_eq("R6 zero command no effect", v, 32'h14);
        wr(A_CMD, 32'h1);
        rd(A_STAT, v); check_eq("R8 program start no effect", v, 32'h14);
        wr(A_CMD, 32'h4);
        rd(A_STAT, v); check_eq("R6 clear done", v, 32'h04);
        rd(A_DATA, v); check_eq("R6 data kept after clear", v, {16'h0, pat(5'd5)});
    endtask

    task automatic t_index_mask();
        logic [31:0] v;
        int c;
        wr(A_INDEX, 32'hFFFF_FFE3);
        rd(A_INDEX, v); check_eq("R3 index masked", v, 32'h03);
        wr(A_CMD, 32'h2);
        check_eq("R3 fa_addr masked", {27'h0, fa_addr}, 32'h3);
        wait_done(c);
        rd(A_DATA, v); check_eq("R3 data block 3", v, {16'h0, pat(5'd3)});
        wr(A_CMD, 32'h4);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        @(negedge clk); mod_en = 1'b0;
        wr(A_CMD, 32'h2);
        rd(A_STAT, v); check_eq("R7 start ignored when disabled", v, 32'h0);
        idle(12);
        rd(A_STAT, v); check_eq("R7 no done when disabled", v, 32'h0);
        check_eq("R7 fa_sel stays low", {31'h0, fa_sel}, 32'h0);
        @(negedge clk); mod_en = 1'b1;
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        int c;
        wr(A_INDEX, 32'd12);
        wr(A_CMD, 32'h2);
        wr(A_INDEX, 32'd9);
        wr(A_CMD, 32'h2);
        check_eq("R9 fa_addr held", {27'h0, fa_addr}, 32'd12);
        wait_done(c);
        check_eq("R7 read not lengthened", c, 32'd4);
        rd(A_DATA, v);  check_eq("R9 data from first index", v, {16'h0, pat(5'd12)});
        rd(A_INDEX, v); check_eq("R9 new index stored", v, 32'd9);
        idle(10);
        rd(A_STAT, v);  check_eq("R7 no restart", v, 32'h14);
        wr(A_CMD, 32'h4);
        wr(A_CMD, 32'h2);
        wait_done(c);
        rd(A_DATA, v);  check_eq("R9 next read uses new index", v, {16'h0, pat(5'd9)});
        wr(A_CMD, 32'h4);
    endtask

    task automatic t_timing();
        logic [31:0] v;
        int c;
        wr(A_TIM, 32'h1FF);
        rd(A_TIM, v); check_eq("R10 timing readback", v, 32'hFF);
        wr(A_TIM, 32'd3);
        wr(A_CMD, 32'h2);
        wait_done(c); check_eq("R5 three cycles", c, 32'd3);
        wr(A_CMD, 32'h4);
        wr(A_TIM, 32'd0);
        rd(A_TIM, v); check_eq("R10 timing zero readback", v, 32'h0);
        wr(A_CMD, 32'h2);
        wait_done(c); check_eq("R5 zero clamps to two", c, 32'd2);
        rd(A_DATA, v); check_eq("R5 data at minimum window", v, {16'h0, pat(5'd9)});
        wr(A_CMD, 32'h4);
        wr(A_TIM, 32'd1);
        wr(A_INDEX, 32'd31);
        wr(A_CMD, 32'h2);
        wait_done(c); check_eq("R5 one clamps to two", c, 32'd2);
        rd(A_DATA, v); check_eq("R5 data block 31", v, {16'h0, pat(5'd31)});
        wr(A_CMD, 32'h4);
        wr(A_TIM, 32'd20);
        wr(A_CMD, 32'h6);
        wait_done(c); check_eq("R5 twenty cycles", c, 32'd20);
        rd(A_STAT, v); check_eq("R6 done after clear and start", v, 32'h14);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_enable();
        t_basic_read();
        t_sticky();
        t_index_mask();
        t_disabled();
        t_busy_ignore();
        t_timing();
        idle(2);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule